// File: doc/BRIEF.md
# Coin Credit Dispense Controller

This block is a synchronous Moore state machine for a hot-drink vending unit. Two coin-detect strobes arrive from the coin acceptor. One marks a small coin worth 5 cents. The other marks a large coin worth 10 cents. The controller keeps the running credit as one of four states: empty, 5, 10 and 15 cents. When the credit reaches the 15-cent state, it raises a dispense output. Paying more than the price does not create a higher state: the credit stops at the 15-cent state, and no change is returned.

The dispense output depends only on the state. It is high for exactly one cycle, because the machine leaves the full state on the next clock edge whatever the inputs are. Both coin strobes high in the same cycle is an illegal combination. It adds no credit and raises an error flag for one cycle. Each coin must appear as a single-cycle strobe.

Top module: `coin_credit_dispenser`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `creditState` = 2'b00, `dispense` = 0 and `coinError` = 0.
- R2: With both coin strobes low, a state below full keeps its `creditState` code at the next edge.
- R3: A small coin alone (`coinSmall`=1, `coinLarge`=0) moves the credit up one step: 00 to 01, 01 to 10, 10 to 11.
- R4: A large coin alone (`coinLarge`=1, `coinSmall`=0) moves 00 to 10 and moves 01 or 10 to 11. Overpayment is absorbed in state 11.
- R5: The `creditState` codes are 00 = 0 cents, 01 = 5 cents, 10 = 10 cents and 11 = 15 cents. `dispense` is 1 exactly when `creditState` is 11.
- R6: From state 11 the next edge always gives state 00, whatever the coin inputs are.
- R7: Both strobes high in a state below full leave `creditState` unchanged at the next edge. `coinError` is 1 for the cycle that follows any edge where both strobes were high, and 0 otherwise.
- R8: Reset is synchronous and active high, and it wins over any coin input sampled at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| coinSmall | input | 1 | One-cycle strobe for a 5-cent coin |
| coinLarge | input | 1 | One-cycle strobe for a 10-cent coin |
| dispense | output | 1 | High only in the full (15-cent) state |
| creditState | output | 2 | Current credit code (00/01/10/11) |
| coinError | output | 1 | One-cycle flag after an illegal double strobe |

## Verification
The bench builds the block with its default parameters: a two-bit credit code, a small coin worth one step and a large coin worth two steps. With these values every state and both saturating paths into the full state can be reached in one or two coins. Directed runs cover each transition, the forced return from full, illegal pairs in every state and reset colliding with coins. A long pseudo-random strobe sequence then walks the remaining orderings against a behavioural model.

// File: rtl/credit_pkg.sv
package credit_pkg;

  // Strobes issued by the control decoder to the credit datapath
  typedef struct packed {
    logic addSmall;    // legal small coin, credit below full
    logic addLarge;    // legal large coin, credit below full
    logic clearFull;   // full state reached: return to empty
    logic flagIllegal; // both strobes seen together
  } ctrlStrobe_t;

endpackage

// File: rtl/credit_control.sv
module credit_control
  import credit_pkg::*;
(
  input  logic        coinSmall,
  input  logic        coinLarge,
  input  logic        isFull,
  output ctrlStrobe_t strobes
);

  logic onlySmall;
  logic onlyLarge;

  assign onlySmall = coinSmall & ~coinLarge;
  assign onlyLarge = coinLarge & ~coinSmall;

  always_comb begin
    strobes             = '0;
    strobes.clearFull   = isFull;
    strobes.addSmall    = onlySmall & ~isFull;
    strobes.addLarge    = onlyLarge & ~isFull;
    strobes.flagIllegal = coinSmall & coinLarge;
  end

endmodule

// File: rtl/credit_datapath.sv
module credit_datapath
  import credit_pkg::*;
#(
  parameter int CREDIT_W   = 2,
  parameter int SMALL_STEP = 1,
  parameter int LARGE_STEP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobes,
  output logic [CREDIT_W-1:0] credit,
  output logic                isFull,
  output logic                errFlag
);

  localparam int SUM_W = CREDIT_W + 1;
  localparam logic [SUM_W-1:0] FULL_CODE = SUM_W'((1 << CREDIT_W) - 1);
  localparam logic [SUM_W-1:0] SMALL_INC = SUM_W'(SMALL_STEP);
  localparam logic [SUM_W-1:0] LARGE_INC = SUM_W'(LARGE_STEP);

  logic [SUM_W-1:0]    sumSmall;
  logic [SUM_W-1:0]    sumLarge;
  logic [CREDIT_W-1:0] satSmall;
  logic [CREDIT_W-1:0] satLarge;

  // Saturating adders: anything past the top code lands in the full state
  always_comb begin
    sumSmall = {1'b0, credit} + SMALL_INC;
    sumLarge = {1'b0, credit} + LARGE_INC;
    satSmall = (sumSmall > FULL_CODE) ? FULL_CODE[CREDIT_W-1:0] : sumSmall[CREDIT_W-1:0];
    satLarge = (sumLarge > FULL_CODE) ? FULL_CODE[CREDIT_W-1:0] : sumLarge[CREDIT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit  <= '0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= strobes.flagIllegal;
      if (strobes.clearFull)     credit <= '0;
      else if (strobes.addSmall) credit <= satSmall;
      else if (strobes.addLarge) credit <= satLarge;
    end
  end

  assign isFull = (credit == FULL_CODE[CREDIT_W-1:0]);

  // R4: a strobe that adds credit never lowers it
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.addLarge || strobes.addSmall) |=> (credit > $past(credit)));

  // R6: a clear strobe always empties the register
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.clearFull |=> (credit == '0));

endmodule

// File: rtl/coin_credit_dispenser.sv
module coin_credit_dispenser
  import credit_pkg::*;
#(
  parameter int CREDIT_W   = 2,
  parameter int SMALL_STEP = 1,
  parameter int LARGE_STEP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coinSmall,
  input  logic                coinLarge,
  output logic                dispense,
  output logic [CREDIT_W-1:0] creditState,
  output logic                coinError
);

  localparam logic [CREDIT_W-1:0] TOP_STATE = {CREDIT_W{1'b1}};

  ctrlStrobe_t strobes;
  logic        fullNow;

  credit_control uCtrl (
    .coinSmall (coinSmall),
    .coinLarge (coinLarge),
    .isFull    (fullNow),
    .strobes   (strobes)
  );

  credit_datapath #(
    .CREDIT_W   (CREDIT_W),
    .SMALL_STEP (SMALL_STEP),
    .LARGE_STEP (LARGE_STEP)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .credit  (creditState),
    .isFull  (fullNow),
    .errFlag (coinError)
  );

  assign dispense = fullNow;

  // R1, R8: reset wins over coins and clears every output
  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (creditState == '0 && !dispense && !coinError));

  // R2: idle inputs hold a non-full state
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!coinSmall && !coinLarge && creditState != TOP_STATE) |=> $stable(creditState));

  // R3: a lone small coin advances by one step
  assert_small_step_R3: assert property (@(posedge clk) disable iff (rst)
    (coinSmall && !coinLarge && creditState != TOP_STATE)
      |=> (creditState == $past(creditState) + CREDIT_W'(1)));

  // R5: dispense appears only in the full state
  assert_dispense_full_R5: assert property (@(posedge clk) disable iff (rst)
    dispense |-> (creditState == TOP_STATE));

  // R6: full state always returns to empty
  assert_full_returns_R6: assert property (@(posedge clk) disable iff (rst)
    (creditState == TOP_STATE) |=> (creditState == '0));

  // R7: illegal pair holds credit and raises the flag
  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (coinSmall && coinLarge && creditState != TOP_STATE)
      |=> ($stable(creditState) && coinError));

  // R7: the flag never appears without a preceding double strobe
  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (rst)
    !(coinSmall && coinLarge) |=> !coinError);

endmodule

// File: tb/tb_coin_credit_dispenser.sv
module tb_coin_credit_dispenser;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       coinSmall;
  logic       coinLarge;
  logic       dispense;
  logic [1:0] creditState;
  logic       coinError;

  int vecCount = 0;
  int missCount = 0;
  int modelState = 0;
  int modelErr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coin_credit_dispenser dut (
    .clk         (clk),
    .rst         (rst),
    .coinSmall   (coinSmall),
    .coinLarge   (coinLarge),
    .dispense    (dispense),
    .creditState (creditState),
    .coinError   (coinError)
  );

  task automatic checkOutputs(input string tag);
    int expDisp;
    expDisp = (modelState == 3) ? 1 : 0;
    vecCount++;
    if (creditState !== 2'(modelState)) begin
      missCount++;
      $display("FAIL %s creditState actual=%b expected=%b", tag, creditState, 2'(modelState));
    end
    if (dispense !== 1'(expDisp)) begin
      missCount++;
      $display("FAIL %s dispense actual=%b expected=%0d", tag, dispense, expDisp);
    end
    if (coinError !== 1'(modelErr)) begin
      missCount++;
      $display("FAIL %s coinError actual=%b expected=%0d", tag, coinError, modelErr);
    end
  endtask

  // Apply one input vector, update the model at the edge, compare mid-low-phase
  task automatic applyVec(input logic s, input logic l, input logic r, input string tag);
    coinSmall = s;
    coinLarge = l;
    rst = r;
    @(posedge clk);
    if (r) begin
      modelState = 0;
      modelErr = 0;
    end else begin
      modelErr = (s && l) ? 1 : 0;
      if (modelState == 3) modelState = 0;
      else if (s && !l) modelState = (modelState + 1 > 3) ? 3 : modelState + 1;
      else if (l && !s) modelState = (modelState + 2 > 3) ? 3 : modelState + 2;
    end
    @(negedge clk);
    checkOutputs(tag);
  endtask

  task automatic reachState(input int target);
    applyVec(0, 0, 1, "R1");
    for (int k = 0; k < target; k++) applyVec(1, 0, 0, "R3");
  endtask

  initial begin
    logic [7:0] lfsr;
    rst = 1'b1;
    coinSmall = 1'b0;
    coinLarge = 1'b0;
    // R1: reset state
    applyVec(0, 0, 1, "R1");
    applyVec(0, 0, 1, "R1");
    // R2: idle holds empty state
    applyVec(0, 0, 0, "R2");
    applyVec(0, 0, 0, "R2");
    // R3: small coins one by one, idles between, then forced return (R6)
    applyVec(1, 0, 0, "R3");
    applyVec(0, 0, 0, "R2");
    applyVec(1, 0, 0, "R3");
    applyVec(0, 0, 0, "R2");
    applyVec(1, 0, 0, "R5");
    applyVec(0, 0, 0, "R6");
    // R4: large coin paths
    applyVec(0, 1, 0, "R4");
    applyVec(0, 1, 0, "R4");
    applyVec(0, 0, 0, "R6");
    applyVec(1, 0, 0, "R4");
    applyVec(0, 1, 0, "R4");
    applyVec(0, 1, 0, "R6");
    // R6: coins while full are ignored; check each input pattern
    for (int p = 0; p < 4; p++) begin
      reachState(3);
      applyVec(p[0], p[1], 0, "R6");
      applyVec(0, 0, 0, "R6");
    end
    // R7: illegal pair in every state
    for (int st = 0; st < 4; st++) begin
      reachState(st);
      applyVec(1, 1, 0, "R7");
      applyVec(0, 0, 0, "R7");
    end
    // R8: reset collides with coins
    reachState(2);
    applyVec(1, 0, 1, "R8");
    applyVec(0, 1, 0, "R8");
    applyVec(1, 1, 1, "R8");
    applyVec(0, 1, 1, "R8");
    // R5: pseudo-random sweep
    lfsr = 8'hA5;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      applyVec(lfsr[0], lfsr[1], (lfsr[7:2] == 6'h3F), "R5");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule